// File: doc/BRIEF.md
# Configuration-Space Request/Response Mailbox Endpoint

This block is the device-side register set of a dword mailbox that lives inside an extended configuration-space capability. The host loads a request into the write-data register one dword at a time and then sets the go bit in control. The endpoint streams the buffered request to a protocol handler and holds busy until the handler's response has been fully captured. It then flags data-object-ready in status.

The host walks the response through the read-data register. A read returns the current dword and does not move on; any write to that register steps to the next dword. An abort path returns the endpoint to idle with error set. An optional interrupt pulses when a response completes or an error is raised, and the host clears the latched interrupt flag by writing one to it.

Top module: `cfgmbox_ep`

## Requirements
- R1: After reset, status, control and the read-data register all read zero and `irq_o` is low.
- R2: The capability register (offset 0x04) returns the interrupt-support parameter in bit 0 and the interrupt message number in bits 11:1.
- R3: Dwords written to offset 0x10 while idle go out on the request port in write order after a control write with bit 31 (go) set. `req_last_o` marks only the final dword. Status bit 0 (busy) reads one from go until the last response dword is accepted.
- R4: When the last response dword is accepted, status bit 31 (ready) sets and busy clears. Offset 0x14 then returns response dwords in arrival order. Reading it does not advance, and any write to it steps to the next dword.
- R5: Once the host steps past the last response dword, ready clears and offset 0x14 reads zero.
- R6: A go with fewer than two buffered request dwords sets status bit 2 (error) and streams nothing. The buffered dwords are discarded.
- R7: A go while busy sets error and leaves busy set.
- R8: A control write with bit 0 (abort) set returns the endpoint to idle in one cycle, with busy clear, ready clear and error set. Both buffers are discarded.
- R9: With control bit 1 (interrupt enable) set, a response completion or an error raises a one-cycle `irq_o` pulse and sets status bit 1 on the same edge. With it clear, neither happens.
- R10: Writing status with bit 1 set clears the interrupt flag. Writing status with bit 1 clear leaves the flag unchanged.
- R11: An accepted go clears error.
- R12: Writes to offset 0x10 while busy are dropped and do not appear in any later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Byte offset within the capability |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| req_valid_o | output | 1 | Request dword valid |
| req_ready_i | input | 1 | Handler accepts request dword |
| req_data_o | output | 32 | Request dword |
| req_last_o | output | 1 | Final request dword |
| rsp_valid_i | input | 1 | Response dword valid |
| rsp_ready_o | output | 1 | Endpoint accepts response dword |
| rsp_data_i | input | 32 | Response dword |
| rsp_last_i | input | 1 | Final response dword |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A stuck state machine shows at the status register on the next read: busy stays high forever, or ready rises with no response taken. A buffer pointer that is off by one shows as reordered, repeated or leftover dwords in the first request or response that follows it. A wrong interrupt flag shows within one cycle as a pulse on `irq_o` with the status bit clear, or the reverse. A stale entry left after an error or abort appears in the very next request stream.

// File: rtl/cfgmbox_pkg.sv
package cfgmbox_pkg;
  localparam int DWORD_W = 32;
  localparam int MSG_W   = 11;

  localparam int OFF_CAP = 'h04;
  localparam int OFF_CTL = 'h08;
  localparam int OFF_STS = 'h0C;
  localparam int OFF_WMB = 'h10;
  localparam int OFF_RMB = 'h14;

  localparam int CTL_ABORT_B = 0;
  localparam int CTL_IE_B    = 1;
  localparam int CTL_GO_B    = 31;
  localparam int STS_BUSY_B  = 0;
  localparam int STS_INT_B   = 1;
  localparam int STS_ERR_B   = 2;
  localparam int STS_RDY_B   = 31;
  localparam int CAP_INT_B   = 0;
  localparam int CAP_MSG_LSB = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} mbox_state_e;
endpackage

// File: rtl/cfgmbox_fifo.sv
module cfgmbox_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               data_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_ptr] <= data_i;
  end

  assign data_o  = mem[rd_ptr];
  assign count_o = cnt;
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/cfgmbox_ctrl.sv
module cfgmbox_ctrl import cfgmbox_pkg::*; #(
  parameter int   CNT_W  = 5,
  parameter logic INT_OK = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic             ctl_abort_i,
  input  logic             ctl_ie_i,
  input  logic             ctl_go_i,
  input  logic             sts_int_clr_i,
  input  logic             rmb_wr_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic             req_hs_i,
  input  logic [CNT_W-1:0] rsp_cnt_i,
  input  logic             rsp_hs_i,
  input  logic             rsp_last_i,
  output mbox_state_e      state_o,
  output logic             busy_o,
  output logic             ready_o,
  output logic             error_o,
  output logic             int_en_o,
  output logic             int_sts_o,
  output logic             irq_o,
  output logic             req_flush_o,
  output logic             rsp_flush_o,
  output logic             rsp_pop_o
);
  mbox_state_e state_q, state_d;
  logic ready_q, error_q, int_en_q, int_sts_q, irq_q;
  logic abort_evt, go_evt, go_ok, go_bad, done_evt, err_set, irq_evt;

  assign abort_evt = ctl_wr_i && ctl_abort_i;
  assign go_evt    = ctl_wr_i && ctl_go_i && !ctl_abort_i;
  assign go_ok     = go_evt && (state_q == ST_IDLE) && (req_cnt_i >= CNT_W'(2));
  assign go_bad    = go_evt && !go_ok;
  assign done_evt  = (state_q == ST_WAIT) && rsp_hs_i && rsp_last_i;
  assign err_set   = abort_evt || go_bad;
  assign irq_evt   = (err_set || done_evt) && int_en_q;
  assign rsp_pop_o = rmb_wr_i && ready_q && (rsp_cnt_i != '0);

  // short go while idle drops the partial request; a running one is left alone
  assign req_flush_o = abort_evt || (go_bad && state_q == ST_IDLE);
  assign rsp_flush_o = abort_evt || go_ok;

  always_comb begin
    state_d = state_q;
    if (abort_evt) state_d = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE: if (go_ok) state_d = ST_SEND;
        ST_SEND: if (req_hs_i && req_cnt_i == CNT_W'(1)) state_d = ST_WAIT;
        ST_WAIT: if (done_evt) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ready_q   <= 1'b0;
      error_q   <= 1'b0;
      int_en_q  <= 1'b0;
      int_sts_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (abort_evt || go_ok)                        ready_q <= 1'b0;
      else if (done_evt)                             ready_q <= 1'b1;
      else if (rsp_pop_o && rsp_cnt_i == CNT_W'(1))  ready_q <= 1'b0;
      if (err_set)    error_q <= 1'b1;
      else if (go_ok) error_q <= 1'b0;
      if (irq_evt)            int_sts_q <= 1'b1;
      else if (sts_int_clr_i) int_sts_q <= 1'b0;
      if (ctl_wr_i) int_en_q <= ctl_ie_i && INT_OK;
      irq_q <= irq_evt;
    end
  end

  assign state_o   = state_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign ready_o   = ready_q;
  assign error_o   = error_q;
  assign int_en_o  = int_en_q;
  assign int_sts_o = int_sts_q;
  assign irq_o     = irq_q;

  assert_busy_ready_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && ready_q));
  assert_ready_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_pop_o && rsp_cnt_i == CNT_W'(1)) |=> !ready_q);
  assert_short_go_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_evt && state_q == ST_IDLE && req_cnt_i < CNT_W'(2)) |=> (error_q && state_q == ST_IDLE));
  assert_busy_go_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_evt && state_q == ST_SEND) |=> (error_q && busy_o));
  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_evt |=> (error_q && state_q == ST_IDLE && !ready_q));
  assert_irq_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> int_sts_q);
endmodule

// File: rtl/cfgmbox_ep.sv
module cfgmbox_ep import cfgmbox_pkg::*; #(
  parameter int               ADDR_W      = 12,
  parameter int               DEPTH       = 16,
  parameter logic             INT_SUPPORT = 1'b1,
  parameter logic [MSG_W-1:0] INT_MSG_NUM = 11'd3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [DWORD_W-1:0] reg_wdata_i,
  output logic [DWORD_W-1:0] reg_rdata_o,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [DWORD_W-1:0] req_data_o,
  output logic               req_last_o,
  input  logic               rsp_valid_i,
  output logic               rsp_ready_o,
  input  logic [DWORD_W-1:0] rsp_data_i,
  input  logic               rsp_last_i,
  output logic               irq_o
);
  localparam int CNT_W = $clog2(DEPTH+1);

  mbox_state_e        state;
  logic               busy, ready, error, int_en, int_sts;
  logic               req_flush, rsp_flush, rsp_pop;
  logic               wr_ctl, wr_sts, wr_wmb, wr_rmb;
  logic               req_push, req_pop, req_full, req_empty;
  logic               rsp_push, rsp_full, rsp_empty;
  logic [CNT_W-1:0]   req_cnt, rsp_cnt;
  logic [DWORD_W-1:0] rsp_head;

  assign wr_ctl = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_CTL));
  assign wr_sts = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_STS));
  assign wr_wmb = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_WMB));
  assign wr_rmb = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_RMB));

  assign req_push    = wr_wmb && (state == ST_IDLE) && !req_full;
  assign req_valid_o = (state == ST_SEND) && !req_empty;
  assign req_last_o  = req_valid_o && (req_cnt == CNT_W'(1));
  assign req_pop     = req_valid_o && req_ready_i;
  assign rsp_ready_o = (state == ST_WAIT) && !rsp_full;
  assign rsp_push    = rsp_valid_i && rsp_ready_o;

  cfgmbox_fifo #(.W(DWORD_W), .DEPTH(DEPTH)) u_req_buf (
    .clk_i, .rst_ni, .flush_i(req_flush), .push_i(req_push), .data_i(reg_wdata_i),
    .pop_i(req_pop), .data_o(req_data_o), .count_o(req_cnt),
    .full_o(req_full), .empty_o(req_empty));

  cfgmbox_fifo #(.W(DWORD_W), .DEPTH(DEPTH)) u_rsp_buf (
    .clk_i, .rst_ni, .flush_i(rsp_flush), .push_i(rsp_push), .data_i(rsp_data_i),
    .pop_i(rsp_pop), .data_o(rsp_head), .count_o(rsp_cnt),
    .full_o(rsp_full), .empty_o(rsp_empty));

  cfgmbox_ctrl #(.CNT_W(CNT_W), .INT_OK(INT_SUPPORT)) u_ctrl (
    .clk_i, .rst_ni,
    .ctl_wr_i(wr_ctl), .ctl_abort_i(reg_wdata_i[CTL_ABORT_B]),
    .ctl_ie_i(reg_wdata_i[CTL_IE_B]), .ctl_go_i(reg_wdata_i[CTL_GO_B]),
    .sts_int_clr_i(wr_sts && reg_wdata_i[STS_INT_B]),
    .rmb_wr_i(wr_rmb), .req_cnt_i(req_cnt), .req_hs_i(req_pop),
    .rsp_cnt_i(rsp_cnt), .rsp_hs_i(rsp_push), .rsp_last_i(rsp_last_i),
    .state_o(state), .busy_o(busy), .ready_o(ready), .error_o(error),
    .int_en_o(int_en), .int_sts_o(int_sts), .irq_o(irq_o),
    .req_flush_o(req_flush), .rsp_flush_o(rsp_flush), .rsp_pop_o(rsp_pop));

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(OFF_CAP): begin
        reg_rdata_o[CAP_INT_B]                = INT_SUPPORT;
        reg_rdata_o[CAP_MSG_LSB +: MSG_W]     = INT_MSG_NUM;
      end
      ADDR_W'(OFF_CTL): reg_rdata_o[CTL_IE_B] = int_en;
      ADDR_W'(OFF_STS): begin
        reg_rdata_o[STS_BUSY_B] = busy;
        reg_rdata_o[STS_INT_B]  = int_sts;
        reg_rdata_o[STS_ERR_B]  = error;
        reg_rdata_o[STS_RDY_B]  = ready;
      end
      ADDR_W'(OFF_RMB): reg_rdata_o = (ready && !rsp_empty) ? rsp_head : '0;
      default: reg_rdata_o = '0;
    endcase
  end

  assert_push_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_wmb && busy) |=> $stable(req_cnt) || (req_cnt < $past(req_cnt)));
endmodule

// File: tb/cfgmbox_ep_tb_top.sv
module cfgmbox_ep_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int A_CAP = 'h04, A_CTL = 'h08, A_STS = 'h0C, A_WMB = 'h10, A_RMB = 'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_last, rsp_ready, irq;
  logic        req_ready = 1'b0;
  logic [31:0] req_data;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        rsp_last = 1'b0;

  int errors = 0, checks = 0;
  int irq_cnt = 0;
  int cap_n = 0;
  logic [31:0] cap_d [64];
  logic        cap_l [64];
  logic [31:0] rsp_buf [16];
  int  rsp_len = 1, rsp_idx = 0;
  bit  rsp_pending = 0, rsp_hold = 0, rsp_kill = 0;
  logic [31:0] req_words [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgmbox_ep dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_data_o(req_data),
    .req_last_o(req_last), .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready),
    .rsp_data_i(rsp_data), .rsp_last_i(rsp_last), .irq_o(irq));

  // handler model: decisions at negedge, handshakes complete at next posedge
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (rsp_kill) rsp_pending = 0;
    if (rsp_pending && !rsp_hold && ($urandom % 4) != 0) begin
      rsp_valid = 1'b1;
      rsp_data  = rsp_buf[rsp_idx];
      rsp_last  = (rsp_idx == rsp_len - 1);
      if (rsp_ready) begin
        if (rsp_last) rsp_pending = 0;
        rsp_idx++;
      end
    end else begin
      rsp_valid = 1'b0;
      rsp_last  = 1'b0;
    end
    req_ready = (($urandom % 4) != 0);
    if (req_valid && req_ready && cap_n < 64) begin
      cap_d[cap_n] = req_data;
      cap_l[cap_n] = req_last;
      cap_n++;
      if (req_last) begin
        rsp_pending = 1;
        rsp_idx = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a[11:0];
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a[11:0];
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl_word(input bit go, input bit abort, input bit ie);
    logic [31:0] w = '0;
    w[31] = go;
    w[1]  = ie;
    w[0]  = abort;
    return w;
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(A_STS, s);
      if (!s[0]) break;
    end
  endtask

  task automatic run_txn(input int nreq, input int nrsp, input bit ie);
    logic [31:0] s, d;
    int base = cap_n;
    int irq0 = irq_cnt;
    rsp_len = nrsp;
    for (int k = 0; k < nrsp; k++) rsp_buf[k] = $urandom;
    for (int k = 0; k < nreq; k++) begin
      req_words[k] = $urandom;
      wr(A_WMB, req_words[k]);
    end
    wr(A_CTL, ctl_word(1, 0, ie));
    rd(A_STS, s);
    chk("R3 busy after go", {31'd0, s[0]}, 32'd1);
    wait_idle();
    chk("R3 request length", cap_n - base, nreq);
    for (int k = 0; k < nreq; k++) begin
      chk("R3 request dword", cap_d[base+k], req_words[k]);
      chk("R3 last flag", {31'd0, cap_l[base+k]}, {31'd0, k == nreq - 1});
    end
    rd(A_STS, s);
    chk("R4 ready set, busy clear", {30'd0, s[31], s[0]}, 32'd2);
    chk("R11 error cleared", {31'd0, s[2]}, 32'd0);
    for (int k = 0; k < nrsp; k++) begin
      rd(A_RMB, d);
      chk("R4 response dword", d, rsp_buf[k]);
      if (k == 0) begin
        rd(A_RMB, d);
        chk("R4 read does not advance", d, rsp_buf[0]);
      end
      wr(A_RMB, 32'h0);
    end
    rd(A_STS, s);
    chk("R5 ready cleared", {31'd0, s[31]}, 32'd0);
    rd(A_RMB, d);
    chk("R5 read after end", d, 32'd0);
    repeat (2) @(negedge clk);
    chk("R9 irq pulses", irq_cnt - irq0, {31'd0, ie});
    chk("R9 int status", {31'd0, s[1]}, {31'd0, ie});
    if (ie) begin
      wr(A_STS, 32'h0);
      rd(A_STS, s);
      chk("R10 zero write keeps flag", {31'd0, s[1]}, 32'd1);
      wr(A_STS, 32'h2);
      rd(A_STS, s);
      chk("R10 w1c clears flag", {31'd0, s[1]}, 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    int base, irq0;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(A_STS, s); chk("R1 status reset", s, 32'd0);
    rd(A_CTL, d); chk("R1 control reset", d, 32'd0);
    rd(A_RMB, d); chk("R1 read mailbox reset", d, 32'd0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    rd(A_CAP, d); chk("R2 capability", d, (32'd3 << 1) | 32'd1);

    run_txn(3, 4, 0);
    run_txn(2, 1, 1);

    // R6: short request
    base = cap_n;
    irq0 = irq_cnt;
    wr(A_WMB, 32'hDEAD_0001);
    wr(A_CTL, ctl_word(1, 0, 1));
    rd(A_STS, s);
    chk("R6 short go error", {29'd0, s[2], 1'b0, s[0]}, 32'd4);
    repeat (4) @(negedge clk);
    chk("R6 nothing streamed", cap_n - base, 0);
    chk("R9 irq on error", irq_cnt - irq0, 1);
    wr(A_STS, 32'h2);
    run_txn(2, 1, 0);

    // R7, R12, R8: go while busy, write while busy, abort
    rsp_hold = 1;
    base = cap_n;
    wr(A_WMB, 32'h1111_0000);
    wr(A_WMB, 32'h1111_0001);
    wr(A_CTL, ctl_word(1, 0, 0));
    for (int i = 0; i < 200 && cap_n - base < 2; i++) @(negedge clk);
    wr(A_WMB, 32'hBAD0_BAD0);
    wr(A_CTL, ctl_word(1, 0, 0));
    rd(A_STS, s);
    chk("R7 busy go error, still busy", {29'd0, s[2], 1'b0, s[0]}, 32'd5);
    wr(A_CTL, ctl_word(0, 1, 0));
    rd(A_STS, s);
    chk("R8 abort state", s, 32'd4);
    rd(A_RMB, d);
    chk("R8 read mailbox empty", d, 32'd0);
    rsp_kill = 1;
    @(negedge clk);
    rsp_kill = 0;
    rsp_hold = 0;
    run_txn(2, 2, 0);  // R12: dropped dword must not appear

    for (int i = 0; i < 10; i++)
      run_txn(2 + int'($urandom % 7), 1 + int'($urandom % 8), bit'($urandom % 2));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule